// File: doc/BRIEF.md
# Power-Down and Wakeup Sequencer

This block decides when a small microcontroller system may stop its clocks and restores them in a fixed order when the system must come back. Software asks for power-down through a one-bit command in a small register file. If no enabled wake source is active at that moment, the block drops both the oscillator-enable and the PLL-enable outputs and waits. Any qualified wake event then restarts the oscillator first. After a programmable oscillator-settle count the PLL is enabled. After a programmable PLL-lock count the block returns to the run state and raises a wakeup interrupt. The interrupt stays up until the processor acknowledges it.

Three wake sources are watched. The first is a dedicated pin. The second is a pin that can be switched between wake duty and plain general-purpose input. The third is a bus-activity indication from the line receiver, which is honoured whether or not the device is attached. Each source has an enable bit and a sticky flag that software clears by writing 1. Each pin has a polarity bit, and both pins are active low after reset. All inputs pass through two-flop synchronizers.

The whole block runs on a free-running always-on clock, `clk_aon`, so it keeps working while the main clock is stopped. The delay counts are given in cycles of that clock. The register port is a plain write strobe with no back-pressure: every write is taken in the cycle it is presented. There is no data stream, so no valid/ready handshake is used.

Top module: `pwr_wake_seq`

## Requirements
- R1: After reset, osc_en and pll_en are 1, wake_irq is 0 and wake_flags is 0. All three sources are enabled, pin B is in wake mode, both pins are active low, the oscillator delay is 12 and the PLL delay is 20.
- R2: A write of 1 in data bit 0 to address 0 while in the run state, with no enabled source asserted, drops osc_en and pll_en together at that clock edge. The PLL enable is never high while the oscillator enable is low.
- R3: In power-down, a qualified pin or bus event changes at an input and osc_en rises 3 cycles later (two synchronizer stages and the state register). pll_en rises (oscillator delay + 1) cycles after osc_en. wake_irq rises (PLL delay + 1) cycles after pll_en. The oscillator delay is written at address 3 and the PLL delay at address 4, both as full data bytes.
- R4: Pin A wakes the system when it is low. Setting bit 4 of the config register at address 1 makes pin A active high, and a low level then no longer wakes.
- R5: Bit 3 of the config register selects pin B's role: 1 means wake input, 0 means general-purpose input. In GPIO mode pin B never wakes the system or sets its flag. In either mode gpio_b shows the pin level two cycles after it changes. Bit 5 sets pin B's polarity (1 = active high).
- R6: An active-high bus_activity input is a wake source in the same way as the pins.
- R7: Config bits 0, 1 and 2 enable pin A, pin B and bus activity. A disabled source neither wakes the system nor sets its flag.
- R8: wake_flags bit 0 (pin A), bit 1 (pin B) and bit 2 (bus) are set when that source is qualified while asleep or at a power-down request. They stay set until software writes 1 to that bit at address 2. Writing 0 leaves a flag unchanged.
- R9: A power-down request made while an enabled source is asserted is ignored. osc_en and pll_en stay 1, and at the next edge wake_irq is 1 and the source's flag is set.
- R10: Once wake_irq is raised it stays high until irq_ack. In any cycle in which irq_ack is high, wake_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Free-running always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 command, 1 config, 2 flags, 3 osc delay, 4 PLL delay) |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | Wakeup interrupt acknowledge |
| wake_pin_a | input | 1 | Dedicated wake pin (asynchronous) |
| wake_pin_b | input | 1 | Dual-role wake / GPIO pin (asynchronous) |
| bus_activity | input | 1 | Bus-line activity indication, active high (asynchronous) |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| wake_irq | output | 1 | Wakeup interrupt to the processor |
| wake_flags | output | 3 | Sticky per-source wake flags |
| gpio_b | output | 1 | Synchronized level of pin B |

## Verification
Each result is due a fixed number of clock edges after its stimulus. A register write takes effect at the edge that takes it. A refused or accepted power-down request shows on the outputs at that same edge. A pin or bus change reaches osc_en after three edges. pll_en follows after the oscillator delay plus one, and wake_irq after the PLL delay plus one. The bench drives inputs and samples outputs on falling edges. It counts the falling edges between a stimulus and each output rise and compares those counts with the exact values above, under both the reset delays and programmed ones. The acknowledge check samples one time step after irq_ack rises, inside the same cycle, to confirm the same-cycle clear.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OSC   = 2'd2,
    ST_PLL   = 2'd3
  } pws_state_e;

  localparam int unsigned NSRC   = 3;
  localparam int unsigned SRC_A  = 0;
  localparam int unsigned SRC_B  = 1;
  localparam int unsigned SRC_BUS = 2;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd2;
  localparam logic [ADDR_W-1:0] A_OSCD = 3'd3;
  localparam logic [ADDR_W-1:0] A_PLLD = 3'd4;

  // config field positions
  localparam int unsigned CFG_W     = 6;
  localparam int unsigned CFG_BMODE = 3;
  localparam int unsigned CFG_POLA  = 4;
  localparam int unsigned CFG_POLB  = 5;
  localparam logic [CFG_W-1:0] CFG_RST = 6'b00_1111;
endpackage

// File: rtl/pws_sync.sv
module pws_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= RST_VAL[i];
        q[i]      <= RST_VAL[i];
      end else begin
        meta_q[i] <= d[i];
        q[i]      <= meta_q[i];
      end
    end
  end
endmodule

// File: rtl/pws_qual.sv
module pws_qual
  import pws_pkg::*;
(
  input  logic [NSRC-1:0] src_sync,
  input  logic [NSRC-1:0] src_en,
  input  logic [1:0]      pin_pol,
  input  logic            b_wake_mode,
  output logic [NSRC-1:0] qual
);
  logic act_a, act_b;

  always_comb begin
    act_a = src_sync[SRC_A] ~^ pin_pol[0];
    act_b = src_sync[SRC_B] ~^ pin_pol[1];
    qual[SRC_A]   = src_en[SRC_A] & act_a;
    qual[SRC_B]   = src_en[SRC_B] & b_wake_mode & act_b;
    qual[SRC_BUS] = src_en[SRC_BUS] & src_sync[SRC_BUS];
  end
endmodule

// File: rtl/pws_regs.sv
module pws_regs
  import pws_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] OSC_DLY_RST = 8'd12,
  parameter logic [DW-1:0] PLL_DLY_RST = 8'd20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              irq_ack,
  input  logic [NSRC-1:0]   flag_set,
  input  logic              irq_set,
  output logic              pd_req,
  output logic [NSRC-1:0]   src_en,
  output logic [1:0]        pin_pol,
  output logic              b_wake_mode,
  output logic [DW-1:0]     osc_dly,
  output logic [DW-1:0]     pll_dly,
  output logic [NSRC-1:0]   flags,
  output logic              wake_irq
);
  logic [CFG_W-1:0] cfg_q;
  logic [NSRC-1:0]  flag_clr;
  logic             irq_q;

  always_comb begin
    pd_req      = wr_en && (wr_addr == A_CMD) && wr_data[0];
    flag_clr    = (wr_en && (wr_addr == A_FLAG)) ? wr_data[NSRC-1:0] : '0;
    src_en      = cfg_q[NSRC-1:0];
    b_wake_mode = cfg_q[CFG_BMODE];
    pin_pol     = {cfg_q[CFG_POLB], cfg_q[CFG_POLA]};
    wake_irq    = irq_q & ~irq_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      osc_dly <= OSC_DLY_RST;
      pll_dly <= PLL_DLY_RST;
    end else if (wr_en) begin
      if (wr_addr == A_CFG)  cfg_q   <= wr_data[CFG_W-1:0];
      if (wr_addr == A_OSCD) osc_dly <= wr_data;
      if (wr_addr == A_PLLD) pll_dly <= wr_data;
    end
  end

  // new events win over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irq_q <= 1'b0;
    end else begin
      flags <= (flags & ~flag_clr) | flag_set;
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_ack) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pws_fsm.sv
module pws_fsm
  import pws_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_req,
  input  logic [NSRC-1:0] qual,
  input  logic [DW-1:0]   osc_dly,
  input  logic [DW-1:0]   pll_dly,
  output logic            osc_en,
  output logic            pll_en,
  output logic            irq_set,
  output logic [NSRC-1:0] flag_set
);
  pws_state_e st_q;
  logic [DW-1:0] cnt_q;
  logic wake_any, cnt_zero, capture;

  always_comb begin
    wake_any = |qual;
    cnt_zero = (cnt_q == '0);
    capture  = (st_q == ST_SLEEP) || ((st_q == ST_RUN) && pd_req);
    flag_set = capture ? qual : '0;
    irq_set  = ((st_q == ST_RUN) && pd_req && wake_any) ||
               ((st_q == ST_PLL) && cnt_zero);
    osc_en   = (st_q != ST_SLEEP);
    pll_en   = (st_q == ST_RUN) || (st_q == ST_PLL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (pd_req && !wake_any) st_q <= ST_SLEEP;
        end
        ST_SLEEP: begin
          if (wake_any) begin
            st_q  <= ST_OSC;
            cnt_q <= osc_dly;
          end
        end
        ST_OSC: begin
          if (cnt_zero) begin
            st_q  <= ST_PLL;
            cnt_q <= pll_dly;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PLL: begin
          if (cnt_zero) st_q <= ST_RUN;
          else          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
  import pws_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] OSC_DLY_RST = 8'd12,
  parameter logic [DW-1:0] PLL_DLY_RST = 8'd20
) (
  input  logic              clk_aon,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              irq_ack,
  input  logic              wake_pin_a,
  input  logic              wake_pin_b,
  input  logic              bus_activity,
  output logic              osc_en,
  output logic              pll_en,
  output logic              wake_irq,
  output logic [NSRC-1:0]   wake_flags,
  output logic              gpio_b
);
  localparam logic [NSRC-1:0] SYNC_RST = 3'b011;

  logic [NSRC-1:0] src_sync, src_en, qual, flag_set;
  logic [1:0]      pin_pol;
  logic            b_wake_mode, pd_req, irq_set;
  logic [DW-1:0]   osc_dly, pll_dly;

  pws_sync #(.W(NSRC), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk_aon), .rst_n(rst_n),
    .d({bus_activity, wake_pin_b, wake_pin_a}),
    .q(src_sync)
  );

  assign gpio_b = src_sync[SRC_B];

  pws_regs #(.DW(DW), .OSC_DLY_RST(OSC_DLY_RST), .PLL_DLY_RST(PLL_DLY_RST)) u_regs (
    .clk(clk_aon), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_ack(irq_ack),
    .flag_set(flag_set), .irq_set(irq_set),
    .pd_req(pd_req), .src_en(src_en), .pin_pol(pin_pol), .b_wake_mode(b_wake_mode),
    .osc_dly(osc_dly), .pll_dly(pll_dly), .flags(wake_flags), .wake_irq(wake_irq)
  );

  pws_qual u_qual (
    .src_sync(src_sync), .src_en(src_en), .pin_pol(pin_pol),
    .b_wake_mode(b_wake_mode), .qual(qual)
  );

  pws_fsm #(.DW(DW)) u_fsm (
    .clk(clk_aon), .rst_n(rst_n), .pd_req(pd_req), .qual(qual),
    .osc_dly(osc_dly), .pll_dly(pll_dly),
    .osc_en(osc_en), .pll_en(pll_en), .irq_set(irq_set), .flag_set(flag_set)
  );
endmodule

// File: rtl/pwr_wake_seq_chk.sv
module pwr_wake_seq_chk
  import pws_pkg::*;
(
  input logic              clk_aon,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [NSRC-1:0]   wr_data_lo,
  input logic              irq_ack,
  input logic              osc_en,
  input logic              pll_en,
  input logic              wake_irq,
  input logic [NSRC-1:0]   wake_flags
);
  assert_pll_off_in_sleep_R2: assert property (@(posedge clk_aon) disable iff (!rst_n)
    !osc_en |-> !pll_en);

  assert_clocks_drop_together_R2: assert property (@(posedge clk_aon) disable iff (!rst_n)
    $fell(osc_en) |-> ($past(pll_en) && !pll_en));

  assert_pll_after_osc_R3: assert property (@(posedge clk_aon) disable iff (!rst_n)
    $rose(pll_en) |-> $past(osc_en));

  assert_irq_with_clocks_R3: assert property (@(posedge clk_aon) disable iff (!rst_n)
    $rose(wake_irq) |-> (osc_en && pll_en));

  assert_ack_clears_R10: assert property (@(posedge clk_aon) disable iff (!rst_n)
    irq_ack |-> !wake_irq);

  assert_irq_held_R10: assert property (@(posedge clk_aon) disable iff (!rst_n)
    wake_irq |=> (wake_irq || irq_ack));

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    assert_flag_sticky_R8: assert property (@(posedge clk_aon) disable iff (!rst_n)
      (wake_flags[i] && !(wr_en && (wr_addr == A_FLAG) && wr_data_lo[i])) |=> wake_flags[i]);
  end
endmodule

bind pwr_wake_seq pwr_wake_seq_chk u_chk (
  .clk_aon(clk_aon), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data_lo(wr_data[2:0]), .irq_ack(irq_ack), .osc_en(osc_en), .pll_en(pll_en),
  .wake_irq(wake_irq), .wake_flags(wake_flags)
);

// File: tb/pwr_wake_seq_tb_top.sv
module pwr_wake_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_aon = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq_ack = 1'b0;
  logic       wake_pin_a = 1'b1;
  logic       wake_pin_b = 1'b1;
  logic       bus_activity = 1'b0;
  logic       osc_en, pll_en, wake_irq, gpio_b;
  logic [2:0] wake_flags;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_aon = ~clk_aon;

  pwr_wake_seq dut_i (
    .clk_aon(clk_aon), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_ack(irq_ack), .wake_pin_a(wake_pin_a),
    .wake_pin_b(wake_pin_b), .bus_activity(bus_activity),
    .osc_en(osc_en), .pll_en(pll_en), .wake_irq(wake_irq),
    .wake_flags(wake_flags), .gpio_b(gpio_b)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_aon);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_aon);
    wr_en = 1'b0;
  endtask

  task automatic go_sleep(input string req);
    wr(3'd0, 8'h01);
    chk(req, "osc_en after request", osc_en, 0);
    chk(req, "pll_en after request", pll_en, 0);
  endtask

  // falling edges until the selected output is high (0 osc, 1 pll, 2 irq)
  task automatic count_to(input int which, output int n);
    n = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk_aon);
      n++;
      if ((which == 0 && osc_en) || (which == 1 && pll_en) || (which == 2 && wake_irq))
        break;
    end
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 300; k++) begin
      if (wake_irq) break;
      @(negedge clk_aon);
    end
  endtask

  task automatic ack_and_clear();
    @(negedge clk_aon);
    irq_ack = 1'b1;
    @(negedge clk_aon);
    irq_ack = 1'b0;
    wr(3'd2, 8'h07);
  endtask

  task automatic t_reset_state();
    chk("R1", "osc_en", osc_en, 1);
    chk("R1", "pll_en", pll_en, 1);
    chk("R1", "wake_irq", wake_irq, 0);
    chk("R1", "wake_flags", wake_flags, 0);
  endtask

  task automatic t_pin_a_default();
    int n;
    go_sleep("R2");
    repeat (4) @(negedge clk_aon);
    chk("R2", "still asleep", osc_en, 0);
    wake_pin_a = 1'b0;
    count_to(0, n); chk("R3", "cycles to osc_en", n, 3);
    chk("R3", "pll_en low at osc restart", pll_en, 0);
    chk("R8", "flag pin A", wake_flags, 3'b001);
    count_to(1, n); chk("R3", "reset osc delay cycles", n, 13);
    count_to(2, n); chk("R3", "reset pll delay cycles", n, 21);
    wake_pin_a = 1'b1;
    repeat (3) @(negedge clk_aon);
    chk("R10", "irq held without ack", wake_irq, 1);
    irq_ack = 1'b1;
    #1;
    chk("R10", "irq low in ack cycle", wake_irq, 0);
    @(negedge clk_aon);
    irq_ack = 1'b0;
    chk("R10", "irq low after ack", wake_irq, 0);
    wr(3'd2, 8'h00);
    chk("R8", "write 0 keeps flag", wake_flags, 3'b001);
    wr(3'd2, 8'h01);
    chk("R8", "write 1 clears flag", wake_flags, 3'b000);
  endtask

  task automatic t_bus_programmed();
    int n;
    wr(3'd3, 8'd3);
    wr(3'd4, 8'd5);
    go_sleep("R2");
    bus_activity = 1'b1;
    count_to(0, n); chk("R6", "bus wake cycles to osc_en", n, 3);
    count_to(1, n); chk("R3", "programmed osc delay cycles", n, 4);
    count_to(2, n); chk("R3", "programmed pll delay cycles", n, 6);
    chk("R8", "flag bus", wake_flags, 3'b100);
    bus_activity = 1'b0;
    ack_and_clear();
  endtask

  task automatic t_pin_b_gpio();
    int n;
    wr(3'd1, 8'h07);              // pin B in GPIO mode
    go_sleep("R2");
    wake_pin_b = 1'b0;
    repeat (2) @(negedge clk_aon);
    chk("R5", "gpio_b follows pin", gpio_b, 0);
    repeat (10) @(negedge clk_aon);
    chk("R5", "GPIO mode does not wake", osc_en, 0);
    chk("R5", "GPIO mode sets no flag", wake_flags, 0);
    wr(3'd1, 8'h0F);              // back to wake mode while pin still low
    chk("R5", "wake mode wakes next edge", osc_en, 0);
    count_to(0, n); chk("R5", "cycles to osc_en after mode switch", n, 1);
    chk("R8", "flag pin B", wake_flags, 3'b010);
    wake_pin_b = 1'b1;
    wait_irq();
    chk("R5", "irq after pin B wake", wake_irq, 1);
    ack_and_clear();
  endtask

  task automatic t_polarity();
    int n;
    wake_pin_a = 1'b0;
    wr(3'd1, 8'h1F);              // pin A active high
    repeat (3) @(negedge clk_aon);
    go_sleep("R4");
    repeat (6) @(negedge clk_aon);
    chk("R4", "low level ignored when active high", osc_en, 0);
    wake_pin_a = 1'b1;
    count_to(0, n); chk("R4", "active-high wake cycles", n, 3);
    wait_irq();
    wake_pin_a = 1'b0;            // idle for active-high before restoring
    wr(3'd1, 8'h0F);
    wake_pin_a = 1'b1;
    ack_and_clear();
    chk("R4", "flags cleared", wake_flags, 0);
  endtask

  task automatic t_disabled();
    int n;
    wr(3'd1, 8'h0B);              // bus source disabled
    go_sleep("R7");
    bus_activity = 1'b1;
    repeat (10) @(negedge clk_aon);
    chk("R7", "disabled bus does not wake", osc_en, 0);
    chk("R7", "disabled bus sets no flag", wake_flags, 0);
    bus_activity = 1'b0;
    repeat (3) @(negedge clk_aon);
    wake_pin_a = 1'b0;
    count_to(0, n); chk("R7", "enabled pin still wakes", n, 3);
    wake_pin_a = 1'b1;
    wait_irq();
    wr(3'd1, 8'h0F);
    ack_and_clear();
  endtask

  task automatic t_reject();
    wake_pin_a = 1'b0;
    repeat (3) @(negedge clk_aon);
    wr(3'd0, 8'h01);
    chk("R9", "osc_en stays on", osc_en, 1);
    chk("R9", "pll_en stays on", pll_en, 1);
    chk("R9", "irq at once", wake_irq, 1);
    chk("R9", "flag set", wake_flags, 3'b001);
    wake_pin_a = 1'b1;
    ack_and_clear();
    chk("R9", "irq cleared", wake_irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk_aon);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk_aon);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_aon);
    t_reset_state();
    t_pin_a_default();
    t_bus_programmed();
    t_pin_b_gpio();
    t_polarity();
    t_disabled();
    t_reject();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule